// File: doc/BRIEF.md
# Edge-Latched Interrupt Controller with Shared Interrupt Pin

This block watches a vector of synchronous status conditions and turns their transitions into sticky interrupt flags. Each condition is registered once to form a readable source register. A rising transition is captured into the flag latch when the bit's rise-enable is set. A falling transition is captured when the bit's fall-enable is set. Software reads and modifies the flags and both enable masks over a simple register bus with address, write data, write strobe and read data.

Every writable register uses paired set and clear addresses. A 1 in the write data sets or clears the matching bit, and a 0 leaves it alone. While any flag is set, the block asks the open-drain interrupt pad to pull low. The pad floats once all flags are cleared. When the part is suspended (by pin or by register bit) and the interrupt-on-shared-pin mode is selected, the block also turns the shared output-enable pad into a push-pull, active-low copy of the interrupt.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the source, flag, rise-enable and fall-enable registers read 0. The open-drain pull request is 0 and the shared pad value is 1 (inactive).
- R2: Reading address 0x08 returns the condition vector as sampled at the most recent clock edge.
- R3: A condition bit that goes 0 to 1 between samples, with its rise-enable bit set, sets the flag bit at that edge.
- R4: A condition bit that goes 1 to 0 between samples, with its fall-enable bit set, sets the flag bit at that edge.
- R5: A transition whose matching enable bit is 0 leaves the flag bit unchanged.
- R6: The address pairs are: flags set 0x0A / clear 0x0B, fall-enable set 0x0C / clear 0x0D, rise-enable set 0x0E / clear 0x0F. A 1 in write data sets or clears that bit and a 0 has no effect. Either address of a pair reads the register.
- R7: The open-drain pull request is 1 exactly while at least one flag bit is set. It stays 1 until a clear write empties the flags.
- R8: The shared pad is driven only when (suspend pin or suspend bit) and the mode bit are all active. Its value is the inverse of the pull request.
- R9: When a flag clear and an enabled transition hit the same bit in one cycle, the bit ends up set.
- R10: Writes to 0x08 have no effect. Reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | W | Synchronous status conditions |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | W | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_rdata_o | output | W | Read data (combinational from address) |
| susp_pin_i | input | 1 | Suspend request from pin |
| susp_bit_i | input | 1 | Suspend request from register bit |
| int_oe_mode_i | input | 1 | Use shared pad as interrupt output while suspended |
| irq_od_o | output | 1 | 1 = pull open-drain interrupt pad low |
| shr_oe_o | output | 1 | Output enable of shared pad |
| shr_val_o | output | 1 | Value for shared pad (active-low interrupt) |

## Verification
Every cycle, the assertions check that each enabled edge lands in the flag latch and that nothing else sets a flag. They also check that a clear removes the written bits unless the same bit has a simultaneous edge, and that the interrupt stays asserted until a clear write. A further check confirms the shared pad is driven only under the suspend-and-mode condition, at the inverted level. Read-back behaviour can only be shown by the bench's register sequences. This covers the dual addresses, zero writes being ignored, writes to the read-only source, and unmapped reads, together with the reset state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam int unsigned NUM_SC = 3;  // 0: flags, 1: fall-enable, 2: rise-enable
  localparam addr_t A_SRC = 8'h08;
  localparam addr_t SC_SET_ADDR [NUM_SC] = '{8'h0A, 8'h0C, 8'h0E};
  localparam addr_t SC_CLR_ADDR [NUM_SC] = '{8'h0B, 8'h0D, 8'h0F};
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_o <= '0;
    else         src_o <= cond_i;
  end

  assign rise_o = cond_i & ~src_o;
  assign fall_o = ~cond_i & src_o;
endmodule

// File: rtl/irq_sc_reg.sv
module irq_sc_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] q_o
);
  // hardware events override a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= ((q_o | set_i) & ~clr_i) | evt_i;
  end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] latch_i,
  input  logic         susp_pin_i,
  input  logic         susp_bit_i,
  input  logic         int_oe_mode_i,
  output logic         irq_od_o,
  output logic         shr_oe_o,
  output logic         shr_val_o
);
  logic irq_act;
  assign irq_act   = |latch_i;
  assign irq_od_o  = irq_act;
  assign shr_oe_o  = (susp_pin_i | susp_bit_i) & int_oe_mode_i;
  assign shr_val_o = ~irq_act;
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [7:0]   reg_addr_i,
  input  logic [W-1:0] reg_wdata_i,
  input  logic         reg_we_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic         susp_pin_i,
  input  logic         susp_bit_i,
  input  logic         int_oe_mode_i,
  output logic         irq_od_o,
  output logic         shr_oe_o,
  output logic         shr_val_o
);
  logic [W-1:0] src_q, rise, fall;
  logic [W-1:0] set_v [NUM_SC];
  logic [W-1:0] clr_v [NUM_SC];
  logic [W-1:0] evt_v [NUM_SC];
  logic [W-1:0] q_v   [NUM_SC];
  logic [W-1:0] latch_q, enl_q, enh_q;

  irq_edge_det #(.W(W)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cond_i(cond_i),
    .src_o (src_q),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign latch_q = q_v[0];
  assign enl_q   = q_v[1];
  assign enh_q   = q_v[2];

  for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
    assign set_v[g] = (reg_we_i && reg_addr_i == SC_SET_ADDR[g]) ? reg_wdata_i : '0;
    assign clr_v[g] = (reg_we_i && reg_addr_i == SC_CLR_ADDR[g]) ? reg_wdata_i : '0;
    if (g == 0) begin : g_evt
      assign evt_v[g] = (rise & enh_q) | (fall & enl_q);
    end else begin : g_noevt
      assign evt_v[g] = '0;
    end
    irq_sc_reg #(.W(W)) i_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .clr_i (clr_v[g]),
      .evt_i (evt_v[g]),
      .q_o   (q_v[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_SRC) reg_rdata_o = src_q;
    for (int k = 0; k < NUM_SC; k++) begin
      if (reg_addr_i == SC_SET_ADDR[k] || reg_addr_i == SC_CLR_ADDR[k])
        reg_rdata_o = q_v[k];
    end
  end

  irq_pin_ctrl #(.W(W)) i_pin (
    .latch_i      (latch_q),
    .susp_pin_i   (susp_pin_i),
    .susp_bit_i   (susp_bit_i),
    .int_oe_mode_i(int_oe_mode_i),
    .irq_od_o     (irq_od_o),
    .shr_oe_o     (shr_oe_o),
    .shr_val_o    (shr_val_o)
  );
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
  import irq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] cond_i,
  input logic [W-1:0] src_q,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] enl_q,
  input logic [W-1:0] enh_q,
  input logic [7:0]   reg_addr_i,
  input logic [W-1:0] reg_wdata_i,
  input logic         reg_we_i,
  input logic         susp_pin_i,
  input logic         susp_bit_i,
  input logic         int_oe_mode_i,
  input logic         irq_od_o,
  input logic         shr_oe_o,
  input logic         shr_val_o
);
  logic [W-1:0] evt;
  logic wr_lset, wr_lclr;
  assign evt     = (cond_i & ~src_q & enh_q) | (~cond_i & src_q & enl_q);
  assign wr_lset = reg_we_i && reg_addr_i == SC_SET_ADDR[0];
  assign wr_lclr = reg_we_i && reg_addr_i == SC_CLR_ADDR[0];

  p_src_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> src_q == $past(cond_i));

  for (genvar i = 0; i < W; i++) begin : g_bit
    p_rise_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cond_i[i] && !src_q[i] && enh_q[i]) |=> latch_q[i]);
    p_fall_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cond_i[i] && src_q[i] && enl_q[i]) |=> latch_q[i]);
    p_clr_race_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_lclr && reg_wdata_i[i] && evt[i]) |=> latch_q[i]);
  end

  p_no_spurious_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lset && evt == '0) |=> (latch_q & ~$past(latch_q)) == '0);

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lclr && evt == '0) |=> (latch_q & $past(reg_wdata_i)) == '0);

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_od_o && !wr_lclr) |=> irq_od_o);

  p_shr_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shr_oe_o |-> ((susp_pin_i || susp_bit_i) && int_oe_mode_i));

  p_shr_val_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shr_oe_o |-> (shr_val_o == !irq_od_o));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.W(W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cond_i       (cond_i),
  .src_q        (src_q),
  .latch_q      (latch_q),
  .enl_q        (enl_q),
  .enh_q        (enh_q),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_we_i     (reg_we_i),
  .susp_pin_i   (susp_pin_i),
  .susp_bit_i   (susp_bit_i),
  .int_oe_mode_i(int_oe_mode_i),
  .irq_od_o     (irq_od_o),
  .shr_oe_o     (shr_oe_o),
  .shr_val_o    (shr_val_o)
);

// File: tb/test_irq_latch_ctrl.sv
module test_irq_latch_ctrl;
  localparam int unsigned W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] cond_i = '0;
  logic [7:0]   reg_addr_i = '0;
  logic [W-1:0] reg_wdata_i = '0;
  logic         reg_we_i = 1'b0;
  logic [W-1:0] reg_rdata_o;
  logic         susp_pin_i = 1'b0;
  logic         susp_bit_i = 1'b0;
  logic         int_oe_mode_i = 1'b0;
  logic         irq_od_o, shr_oe_o, shr_val_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  irq_latch_ctrl #(.W(W)) i_irq_latch_ctrl (.*);

  typedef struct packed {
    logic [7:0] cond;
    logic       we;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] raddr;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{8'h00, 1'b1, 8'h0E, 8'h0F, 8'h0E, 8'h0F},  // R6 rise-enable set
    '{8'h00, 1'b1, 8'h0C, 8'hF0, 8'h0D, 8'hF0},  // R6 fall-enable via clear addr
    '{8'h03, 1'b0, 8'h00, 8'h00, 8'h0A, 8'h03},  // R3 rising, enabled
    '{8'h03, 1'b1, 8'h0B, 8'h01, 8'h0A, 8'h02},  // R6 clear bit 0
    '{8'h00, 1'b0, 8'h00, 8'h00, 8'h0B, 8'h02},  // R5 fall not enabled
    '{8'h30, 1'b0, 8'h00, 8'h00, 8'h0A, 8'h02},  // R5 rise not enabled
    '{8'h00, 1'b0, 8'h00, 8'h00, 8'h0A, 8'h32},  // R4 falling, enabled
    '{8'h00, 1'b1, 8'h0A, 8'h00, 8'h0A, 8'h32},  // R6 zero write ignored
    '{8'h00, 1'b1, 8'h0B, 8'hFF, 8'h0A, 8'h00},  // R6 clear all
    '{8'hA5, 1'b0, 8'h00, 8'h00, 8'h08, 8'hA5},  // R2 source read
    '{8'hA5, 1'b0, 8'h00, 8'h00, 8'h0A, 8'h05},  // R3 mixed pattern
    '{8'h25, 1'b1, 8'h0B, 8'hFF, 8'h0A, 8'h80},  // R9 edge beats clear
    '{8'h25, 1'b1, 8'h08, 8'hFF, 8'h08, 8'h25},  // R10 source write ignored
    '{8'h25, 1'b0, 8'h00, 8'h00, 8'h20, 8'h00},  // R10 unmapped read
    '{8'h25, 1'b1, 8'h0F, 8'hFF, 8'h0E, 8'h00}   // R6 rise-enable clear
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_we_i = 1'b0;
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    susp_pin_i = 1'b1;
    int_oe_mode_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(8'h08, d); chk("R1 src", d, 8'h00);
    rd(8'h0A, d); chk("R1 flags", d, 8'h00);
    rd(8'h0C, d); chk("R1 fall-en", d, 8'h00);
    rd(8'h0E, d); chk("R1 rise-en", d, 8'h00);
    chk("R1 irq", {7'd0, irq_od_o}, 8'h00);
    chk("R1 shared val", {7'd0, shr_val_o}, 8'h01);
    susp_pin_i = 1'b0;
    int_oe_mode_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      cond_i = VT[i].cond;
      reg_we_i = VT[i].we;
      reg_addr_i = VT[i].addr;
      reg_wdata_i = VT[i].wdata;
      @(negedge clk_i);
      rd(VT[i].raddr, d);
      chk($sformatf("vector %0d", i), d, VT[i].exp);
    end

    // flags now 0x80
    chk("R7 irq asserted", {7'd0, irq_od_o}, 8'h01);
    chk("R8 no suspend", {7'd0, shr_oe_o}, 8'h00);
    susp_pin_i = 1'b1;
    #1 chk("R8 suspend without mode", {7'd0, shr_oe_o}, 8'h00);
    susp_pin_i = 1'b0;
    susp_bit_i = 1'b1;
    int_oe_mode_i = 1'b1;
    #1 chk("R8 bit suspend with mode oe", {7'd0, shr_oe_o}, 8'h01);
    chk("R8 shared val low", {7'd0, shr_val_o}, 8'h00);

    // partial clear with 0 bits keeps irq
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 8'h0B; reg_wdata_i = 8'h7F;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    #1 chk("R7 irq kept", {7'd0, irq_od_o}, 8'h01);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 8'h0B; reg_wdata_i = 8'h80;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    #1 chk("R7 irq released", {7'd0, irq_od_o}, 8'h00);
    chk("R8 shared val high", {7'd0, shr_val_o}, 8'h01);

    // software set of a flag raises irq
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 8'h0A; reg_wdata_i = 8'h10;
    @(negedge clk_i);
    rd(8'h0B, d); chk("R6 flag set readback", d, 8'h10);
    chk("R7 irq from set", {7'd0, irq_od_o}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule